// File: doc/BRIEF.md
# Checked Register and RAM Slave for AHB-Lite

This block answers single-word AHB-Lite transfers that target a small bank of read/write control registers and a word-addressed local RAM window. Each transfer is checked during its address phase against three rules before it may touch storage. The first rule is privilege: a configuration input can refuse masters that do not signal privileged mode. The second is alignment: a second configuration input can turn a misaligned address into a fault. The third is decoding: the address must land in one of the two implemented windows. A transfer must also be a 32-bit transfer.

Accepted transfers complete with zero wait states and an OKAY response. A refused transfer gets the two-cycle ERROR response. It leaves every register and RAM word untouched and returns zero read data. Idle and busy cycles get OKAY and have no side effects. With the default parameters the registers occupy byte addresses 0x000 to 0x01F (eight words) and the RAM occupies 0x100 to 0x1FF (64 words). Every other address is unmapped.

Top module: `ahb_chk_slave`

## Requirements
- R1: After reset `hreadyout` is 1, `hresp` is 0 (OKAY), `hrdata` is zero, and every register and RAM word reads back as zero.
- R2: A NONSEQ transfer (`htrans` = 2'b10) or SEQ transfer (2'b11) with word size, where the word index is `haddr[11:2]` and falls in the register window, completes with zero wait and OKAY. A write stores `hwdata` from the data phase. A read returns the stored word on `hrdata` in the data phase.
- R3: The same rules apply to the RAM window starting at byte address 0x100. Word `haddr[11:2]` − 0x40 is the RAM entry.
- R4: When `cfg_priv_only` is 1, a transfer with `hprot[1]` = 0 (non-privileged) is refused with ERROR, in both the register window and the RAM window. When `hprot[1]` = 1, or when `cfg_priv_only` is 0, privilege refuses nothing.
- R5: When `cfg_misalign_err` is 1, any nonzero `haddr[1:0]` is refused with ERROR. When it is 0, `haddr[1:0]` is ignored and the access goes to the containing word.
- R6: An address whose word lies in neither window is refused with ERROR.
- R7: An `hsize` other than 3'b010 (32-bit) is refused with ERROR.
- R8: The ERROR response takes exactly two cycles. In the first, `hreadyout` = 0 and `hresp` = 1. In the second, `hreadyout` = 1 and `hresp` = 1.
- R9: A refused write changes no register or RAM word. A refused transfer drives `hrdata` to zero.
- R10: IDLE (2'b00) and BUSY (2'b01) transfers, and any transfer with `hsel` = 0, get a zero-wait OKAY and change no storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_priv_only | input | 1 | 1: refuse non-privileged masters |
| cfg_misalign_err | input | 1 | 1: misaligned address gives ERROR |
| hsel | input | 1 | Slave select |
| haddr | input | 12 | Byte address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write |
| hsize | input | 3 | Transfer size, only 3'b010 accepted |
| hprot | input | 4 | Protection; bit 1 = privileged |
| hwdata | input | 32 | Write data (data phase) |
| hready | input | 1 | Bus ready, previous transfer done |
| hrdata | output | 32 | Read data |
| hreadyout | output | 1 | Slave ready |
| hresp | output | 1 | 0 = OKAY, 1 = ERROR |

## Verification
The embedded assertions watch the shape of every response on every cycle. A first error cycle must be followed by a second, a second must be preceded by a first, and OKAY must never stall. They also require that no store is written while an error is in flight, that read data is zero during an error, that a non-privileged transfer under privileged-only mode is always refused, and that an unmapped target is always refused. Only the bench's scenarios can show the effects on contents. These cover whether a write lands in the right word when low address bits are ignored, whether a refused or idle write really left storage intact, and whether the window boundaries sit at the intended addresses. The bench sweeps the privilege mode, the alignment mode and the target range together and confirms these by reading the words back.

// File: rtl/ahb_chk_pkg.sv
package ahb_chk_pkg;

    localparam logic [1:0] TRANS_IDLE   = 2'b00;
    localparam logic [1:0] TRANS_BUSY   = 2'b01;
    localparam logic [2:0] SIZE_WORD    = 3'b010;
    localparam int unsigned DATA_W      = 32;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_REG  = 2'd1,
        TGT_RAM  = 2'd2
    } target_e;

    typedef enum logic [1:0] {
        RSP_OKAY = 2'd0,
        RSP_ERR1 = 2'd1,
        RSP_ERR2 = 2'd2
    } rsp_state_e;

    typedef struct packed {
        logic bad_size;
        logic no_priv;
        logic misaligned;
        logic unmapped;
    } fault_t;

    typedef struct packed {
        logic    active;
        logic    reject;
        target_e tgt;
    } verdict_t;

    function automatic logic word_in_window(input int unsigned word,
                                            input int unsigned first,
                                            input int unsigned count);
        return (word >= first) && (word < first + count);
    endfunction

    function automatic logic any_fault(input fault_t f);
        return f.bad_size | f.no_priv | f.misaligned | f.unmapped;
    endfunction

endpackage

// File: rtl/ahb_chk_access_check.sv
module ahb_chk_access_check
    import ahb_chk_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned REG_BASE  = 'h000,
    parameter int unsigned NUM_REGS  = 8,
    parameter int unsigned RAM_BASE  = 'h100,
    parameter int unsigned RAM_WORDS = 64,
    parameter int unsigned IDX_W     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_priv_only,
    input  logic              cfg_misalign_err,
    input  logic              hsel,
    input  logic              hready,
    input  logic [1:0]        htrans,
    input  logic [2:0]        hsize,
    input  logic [3:0]        hprot,
    input  logic [ADDR_W-1:0] haddr,
    output verdict_t          verdict,
    output fault_t            faults,
    output logic [IDX_W-1:0]  idx
);

    localparam int unsigned REG_W0 = REG_BASE / 4;
    localparam int unsigned RAM_W0 = RAM_BASE / 4;

    int unsigned word;
    logic        reg_hit;
    logic        ram_hit;

    always_comb begin
        word    = 32'(haddr[ADDR_W-1:2]);
        reg_hit = word_in_window(word, REG_W0, NUM_REGS);
        ram_hit = word_in_window(word, RAM_W0, RAM_WORDS);

        faults.bad_size   = (hsize != SIZE_WORD);
        faults.no_priv    = cfg_priv_only && !hprot[1];
        faults.misaligned = cfg_misalign_err && (haddr[1:0] != 2'b00);
        faults.unmapped   = !reg_hit && !ram_hit;

        verdict.active = hsel && hready && htrans[1];
        verdict.reject = verdict.active && any_fault(faults);
        if (reg_hit)      verdict.tgt = TGT_REG;
        else if (ram_hit) verdict.tgt = TGT_RAM;
        else              verdict.tgt = TGT_NONE;

        if (reg_hit) idx = IDX_W'(word - REG_W0);
        else         idx = IDX_W'(word - RAM_W0);
    end

    AST_PRIV_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (verdict.active && cfg_priv_only && !hprot[1]) |-> verdict.reject); // R4
    AST_UNMAPPED_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (verdict.active && verdict.tgt == TGT_NONE) |-> verdict.reject); // R6
    AST_SIZE_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (verdict.active && hsize != SIZE_WORD) |-> verdict.reject); // R7
    AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (rst)
        (!htrans[1] || !hsel) |-> !verdict.active); // R10

endmodule

// File: rtl/ahb_chk_word_store.sv
module ahb_chk_word_store
    import ahb_chk_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned LW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (we && (32'(widx) == i))
                mem[i] <= wdata;
        end
    end

    always_comb begin
        if (32'(ridx) < DEPTH) rdata = mem[ridx[LW-1:0]];
        else                   rdata = '0;
    end

endmodule

// File: rtl/ahb_chk_resp_ctrl.sv
module ahb_chk_resp_ctrl
    import ahb_chk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic reject,
    output logic hreadyout,
    output logic hresp
);

    rsp_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RSP_OKAY;
        end else begin
            unique case (state)
                RSP_ERR1: state <= RSP_ERR2;
                default:  state <= (accept && reject) ? RSP_ERR1 : RSP_OKAY;
            endcase
        end
    end

    assign hreadyout = (state != RSP_ERR1);
    assign hresp     = (state != RSP_OKAY);

    AST_ERR_FIRST_THEN_SECOND: assert property (@(posedge clk) disable iff (rst)
        (hresp && !hreadyout) |=> (hresp && hreadyout)); // R8
    AST_ERR_SECOND_HAS_FIRST: assert property (@(posedge clk) disable iff (rst)
        (hresp && hreadyout) |-> $past(hresp && !hreadyout)); // R8
    AST_OKAY_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
        !hresp |-> hreadyout); // R2

endmodule

// File: rtl/ahb_chk_slave.sv
module ahb_chk_slave
    import ahb_chk_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned REG_BASE  = 'h000,
    parameter int unsigned NUM_REGS  = 8,
    parameter int unsigned RAM_BASE  = 'h100,
    parameter int unsigned RAM_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_priv_only,
    input  logic              cfg_misalign_err,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [3:0]        hprot,
    input  logic [31:0]       hwdata,
    input  logic              hready,
    output logic [31:0]       hrdata,
    output logic              hreadyout,
    output logic              hresp
);

    localparam int unsigned MAX_WORDS = (NUM_REGS > RAM_WORDS) ? NUM_REGS : RAM_WORDS;
    localparam int unsigned IDX_W     = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

    verdict_t          verdict;
    fault_t            faults;
    logic [IDX_W-1:0]  ap_idx;

    logic              dp_wr;
    logic              dp_rd;
    target_e           dp_tgt;
    logic [IDX_W-1:0]  dp_idx;

    logic              reg_we;
    logic              ram_we;
    logic [DATA_W-1:0] reg_rdata;
    logic [DATA_W-1:0] ram_rdata;

    ahb_chk_access_check #(
        .ADDR_W    (ADDR_W),
        .REG_BASE  (REG_BASE),
        .NUM_REGS  (NUM_REGS),
        .RAM_BASE  (RAM_BASE),
        .RAM_WORDS (RAM_WORDS),
        .IDX_W     (IDX_W)
    ) check_i (
        .clk              (clk),
        .rst              (rst),
        .cfg_priv_only    (cfg_priv_only),
        .cfg_misalign_err (cfg_misalign_err),
        .hsel             (hsel),
        .hready           (hready),
        .htrans           (htrans),
        .hsize            (hsize),
        .hprot            (hprot),
        .haddr            (haddr),
        .verdict          (verdict),
        .faults           (faults),
        .idx              (ap_idx)
    );

    // Data-phase state: captured whenever the bus advances.
    always_ff @(posedge clk) begin
        if (rst) begin
            dp_wr  <= 1'b0;
            dp_rd  <= 1'b0;
            dp_tgt <= TGT_NONE;
            dp_idx <= '0;
        end else if (hready) begin
            dp_wr  <= verdict.active && !verdict.reject && hwrite;
            dp_rd  <= verdict.active && !verdict.reject && !hwrite;
            dp_tgt <= verdict.tgt;
            dp_idx <= ap_idx;
        end
    end

    assign reg_we = dp_wr && hready && (dp_tgt == TGT_REG);
    assign ram_we = dp_wr && hready && (dp_tgt == TGT_RAM);

    ahb_chk_word_store #(
        .DEPTH (NUM_REGS),
        .IDX_W (IDX_W)
    ) regs_i (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .widx  (dp_idx),
        .wdata (hwdata),
        .ridx  (dp_idx),
        .rdata (reg_rdata)
    );

    ahb_chk_word_store #(
        .DEPTH (RAM_WORDS),
        .IDX_W (IDX_W)
    ) ram_i (
        .clk   (clk),
        .rst   (rst),
        .we    (ram_we),
        .widx  (dp_idx),
        .wdata (hwdata),
        .ridx  (dp_idx),
        .rdata (ram_rdata)
    );

    always_comb begin
        if (dp_rd && dp_tgt == TGT_REG)      hrdata = reg_rdata;
        else if (dp_rd && dp_tgt == TGT_RAM) hrdata = ram_rdata;
        else                                 hrdata = '0;
    end

    ahb_chk_resp_ctrl resp_i (
        .clk       (clk),
        .rst       (rst),
        .accept    (verdict.active),
        .reject    (verdict.reject),
        .hreadyout (hreadyout),
        .hresp     (hresp)
    );

    AST_NO_STORE_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        hresp |-> !(reg_we || ram_we)); // R9
    AST_ERR_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        hresp |-> (hrdata == '0)); // R9
    AST_MISALIGN_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (verdict.active && cfg_misalign_err && haddr[1:0] != 2'b00) |=> hresp); // R5

endmodule

// File: tb/ahb_chk_slave_tb_top.sv
module ahb_chk_slave_tb_top;

    typedef struct packed {
        bit        priv_only;
        bit        mis_err;
        bit [1:0]  trans;
        bit        write;
        bit [2:0]  size;
        bit        prot1;
        bit [11:0] addr;
        bit [31:0] wdata;
        bit        exp_err;
        bit [7:0]  tag;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,2'b10,1'b1,3'd2,1'b0,12'h004,32'hA1A1_0001,1'b0,8'd2},  // R2 nonpriv ok when mode off
        '{1'b0,1'b0,2'b10,1'b0,3'd2,1'b0,12'h004,32'h0,        1'b0,8'd2},  // R2 read back
        '{1'b1,1'b0,2'b10,1'b1,3'd2,1'b0,12'h004,32'hDEAD_0001,1'b1,8'd4},  // R4 refused write
        '{1'b1,1'b0,2'b10,1'b0,3'd2,1'b0,12'h004,32'h0,        1'b1,8'd4},  // R4 refused read
        '{1'b1,1'b0,2'b10,1'b1,3'd2,1'b1,12'h008,32'hB2B2_0002,1'b0,8'd4},  // R4 privileged ok
        '{1'b1,1'b0,2'b10,1'b0,3'd2,1'b1,12'h004,32'h0,        1'b0,8'd9},  // R9 reg1 intact
        '{1'b1,1'b0,2'b10,1'b1,3'd2,1'b0,12'h104,32'hDEAD_0002,1'b1,8'd4},  // R4 RAM refused
        '{1'b1,1'b0,2'b10,1'b1,3'd2,1'b1,12'h104,32'hC3C3_0003,1'b0,8'd3},  // R3 RAM write
        '{1'b0,1'b0,2'b10,1'b0,3'd2,1'b0,12'h104,32'h0,        1'b0,8'd3},  // R3 RAM read
        '{1'b0,1'b1,2'b10,1'b1,3'd2,1'b1,12'h00E,32'hDEAD_0003,1'b1,8'd5},  // R5 misaligned reg
        '{1'b0,1'b1,2'b10,1'b0,3'd2,1'b1,12'h105,32'h0,        1'b1,8'd5},  // R5 misaligned RAM
        '{1'b0,1'b0,2'b10,1'b1,3'd2,1'b1,12'h00D,32'hD4D4_0004,1'b0,8'd5},  // R5 low bits ignored
        '{1'b0,1'b0,2'b10,1'b0,3'd2,1'b1,12'h00F,32'h0,        1'b0,8'd5},  // R5 reads reg3
        '{1'b0,1'b0,2'b10,1'b1,3'd2,1'b1,12'h1FB,32'hE5E5_0005,1'b0,8'd5},  // R5 RAM word 62
        '{1'b0,1'b1,2'b10,1'b0,3'd2,1'b1,12'h1F8,32'h0,        1'b0,8'd5},  // R5 aligned read
        '{1'b0,1'b0,2'b10,1'b1,3'd2,1'b1,12'h020,32'hDEAD_0004,1'b1,8'd6},  // R6 past last reg
        '{1'b0,1'b0,2'b10,1'b0,3'd2,1'b1,12'h200,32'h0,        1'b1,8'd6},  // R6 past RAM
        '{1'b1,1'b1,2'b10,1'b0,3'd2,1'b1,12'hFFC,32'h0,        1'b1,8'd6},  // R6 top of space
        '{1'b0,1'b0,2'b10,1'b1,3'd2,1'b1,12'h01C,32'hF6F6_0006,1'b0,8'd2},  // R2 last reg
        '{1'b0,1'b0,2'b10,1'b1,3'd2,1'b1,12'h0FC,32'hDEAD_0005,1'b1,8'd6},  // R6 below RAM
        '{1'b0,1'b0,2'b11,1'b1,3'd2,1'b1,12'h1FC,32'h0707_0007,1'b0,8'd3},  // R3 last RAM, SEQ
        '{1'b0,1'b0,2'b10,1'b1,3'd1,1'b1,12'h010,32'hDEAD_0006,1'b1,8'd7},  // R7 halfword
        '{1'b0,1'b0,2'b10,1'b1,3'd0,1'b1,12'h100,32'hDEAD_0007,1'b1,8'd7},  // R7 byte
        '{1'b0,1'b0,2'b10,1'b0,3'd3,1'b1,12'h010,32'h0,        1'b1,8'd7},  // R7 doubleword
        '{1'b1,1'b1,2'b10,1'b0,3'd2,1'b0,12'h101,32'h0,        1'b1,8'd8},  // R8 several faults
        '{1'b0,1'b0,2'b00,1'b1,3'd2,1'b1,12'h010,32'hDEAD_0008,1'b0,8'd10}, // R10 IDLE write
        '{1'b0,1'b0,2'b01,1'b1,3'd2,1'b1,12'h100,32'hDEAD_0009,1'b0,8'd10}, // R10 BUSY write
        '{1'b1,1'b1,2'b10,1'b0,3'd2,1'b1,12'h010,32'h0,        1'b0,8'd10}, // R10 reg4 still 0
        '{1'b1,1'b1,2'b10,1'b0,3'd2,1'b1,12'h100,32'h0,        1'b0,8'd10}, // R10 ram0 still 0
        '{1'b1,1'b1,2'b10,1'b0,3'd2,1'b1,12'h01C,32'h0,        1'b0,8'd2},  // R2 last reg read
        '{1'b0,1'b0,2'b10,1'b0,3'd2,1'b0,12'h008,32'h0,        1'b0,8'd9}   // R9 reg2 intact
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_priv_only = 1'b0;
    logic        cfg_misalign_err = 1'b0;
    logic        hsel = 1'b0;
    logic [11:0] haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize = 3'd2;
    logic [3:0]  hprot = 4'b0011;
    logic [31:0] hwdata = '0;
    logic        hready;
    logic [31:0] hrdata;
    logic        hreadyout;
    logic        hresp;

    int          n_tests = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    logic [31:0] sh_regs [8];
    logic [31:0] sh_ram [64];

    always #5 clk = ~clk;
    assign hready = hreadyout;

    ahb_chk_slave dut_i (
        .clk              (clk),
        .rst              (rst),
        .cfg_priv_only    (cfg_priv_only),
        .cfg_misalign_err (cfg_misalign_err),
        .hsel             (hsel),
        .haddr            (haddr),
        .htrans           (htrans),
        .hwrite           (hwrite),
        .hsize            (hsize),
        .hprot            (hprot),
        .hwdata           (hwdata),
        .hready           (hready),
        .hrdata           (hrdata),
        .hreadyout        (hreadyout),
        .hresp            (hresp)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int w = int'(a[11:2]);
        if (w < 8) return sh_regs[w];
        return sh_ram[w - 64];
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        int w = int'(a[11:2]);
        if (w < 8) sh_regs[w] = d;
        else       sh_ram[w - 64] = d;
    endtask

    task automatic xfer(input vec_t v, input bit sel);
        string tg = $sformatf("R%0d", v.tag);
        @(negedge clk);
        cfg_priv_only    = v.priv_only;
        cfg_misalign_err = v.mis_err;
        hsel   = sel;
        haddr  = v.addr;
        htrans = v.trans;
        hwrite = v.write;
        hsize  = v.size;
        hprot  = {2'b00, v.prot1, 1'b1};
        @(negedge clk);
        hwdata = v.wdata;
        hsel   = 1'b0;
        htrans = 2'b00;
        #1;
        if (v.exp_err) begin
            check(hreadyout == 1'b0 && hresp == 1'b1, {tg, " err cycle1 (R8)"},
                  {30'd0, hreadyout, hresp}, 32'h1);
            check(hrdata == 32'h0, {tg, " refused rdata (R9)"}, hrdata, 32'h0);
            @(negedge clk);
            #1;
            check(hreadyout == 1'b1 && hresp == 1'b1, {tg, " err cycle2 (R8)"},
                  {30'd0, hreadyout, hresp}, 32'h3);
        end else begin
            check(hreadyout == 1'b1 && hresp == 1'b0, {tg, " okay zero wait"},
                  {30'd0, hreadyout, hresp}, 32'h2);
            if (sel && v.trans[1] && !v.write)
                check(hrdata == model_read(v.addr), {tg, " read data"}, hrdata,
                      model_read(v.addr));
            else
                check(hrdata == 32'h0, {tg, " no read data"}, hrdata, 32'h0);
            if (sel && v.trans[1] && v.write) model_write(v.addr, v.wdata);
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) sh_regs[i] = '0;
        for (int i = 0; i < 64; i++) sh_ram[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        check(hreadyout == 1'b1 && hresp == 1'b0 && hrdata == 32'h0, "R1 reset outputs",
              {hrdata[29:0], hreadyout, hresp}, 32'h2);
        rst = 1'b0;
        xfer('{1'b0,1'b0,2'b10,1'b0,3'd2,1'b1,12'h000,32'h0,1'b0,8'd1}, 1'b1); // R1 reg0
        xfer('{1'b0,1'b0,2'b10,1'b0,3'd2,1'b1,12'h1FC,32'h0,1'b0,8'd1}, 1'b1); // R1 ram63

        for (int i = 0; i < NV; i++) xfer(VECS[i], 1'b1);

        // R10: write with hsel low must not land.
        xfer('{1'b0,1'b0,2'b10,1'b1,3'd2,1'b1,12'h014,32'hDEAD_00AA,1'b0,8'd10}, 1'b0);
        xfer('{1'b0,1'b0,2'b10,1'b0,3'd2,1'b1,12'h014,32'h0,1'b0,8'd10}, 1'b1);

        // R9: back-to-back refused writes across modes, then full readback.
        xfer('{1'b1,1'b0,2'b10,1'b1,3'd2,1'b0,12'h018,32'hDEAD_00BB,1'b1,8'd9}, 1'b1);
        xfer('{1'b0,1'b1,2'b10,1'b1,3'd2,1'b1,12'h11A,32'hDEAD_00CC,1'b1,8'd9}, 1'b1);
        for (int i = 0; i < 8; i++)
            xfer('{1'b0,1'b0,2'b10,1'b0,3'd2,1'b1,12'(i*4),32'h0,1'b0,8'd9}, 1'b1);
        for (int i = 0; i < 64; i++)
            xfer('{1'b1,1'b1,2'b10,1'b0,3'd2,1'b1,12'('h100 + i*4),32'h0,1'b0,8'd3}, 1'b1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule